// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. It does this by shifting the segment four places left and adding the offset. It holds six base and pointer registers: the segments for code, data, stack and extra/string-destination accesses, plus the instruction pointer and the stack pointer. Each request names an access kind. The kind decides which segment is used and where the offset comes from: the instruction pointer, the stack pointer, or a supplied effective address.

A request is one cycle long, with `req_go` high. Exactly one cycle later the address appears on `addr_out` and `addr_vld` pulses high. Fetch requests move the instruction pointer forward by the supplied instruction length. Push requests lower the stack pointer before the address is formed. Pop requests form the address first and then raise the stack pointer. A separate write port loads any of the six registers, so the surrounding execution logic can set up segments and pointers.

Top module: `seg_addr_gen`

## Requirements
- R1: When `rst_n` is low at a clock edge, the code segment becomes FFFFh and the data, stack and extra segments, the instruction pointer and the stack pointer become 0000h. `addr_vld` goes low.
- R2: A request with `req_go` high and `req_kind` below 6 drives `addr_vld` high in the next cycle only, with `addr_out` = (segment × 16 + offset). Kinds 6 and 7 produce no valid output and change no register.
- R3: Kind 0 (fetch) uses the code segment with the instruction pointer as offset. Afterwards the instruction pointer grows by `ins_len`, modulo 2^16.
- R4: Kind 1 (data) uses the data segment with `req_ea` as offset.
- R5: Kind 2 (extra) uses the extra segment with `req_ea` as offset.
- R6: Kind 3 (push) first lowers the stack pointer by 2, modulo 2^16, and then forms the address from the stack segment and the new stack pointer.
- R7: Kind 4 (pop) forms the address from the stack segment and the current stack pointer, then raises the stack pointer by 2, modulo 2^16.
- R8: Kind 5 (stack read) uses the stack segment with the stack pointer as offset and leaves the stack pointer unchanged.
- R9: When `wr_en` is high, `wr_data` is loaded at the clock edge into the register chosen by `wr_sel`: 0 code segment, 1 data segment, 2 stack segment, 3 extra segment, 4 instruction pointer, 5 stack pointer. Codes 6 and 7 write nothing. A request in the same cycle uses the old values. If that request also steps the same register, the written value wins.
- R10: Any carry out of bit 19 of the address sum is dropped. For example, FFFFh:0010h gives 00000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_go | input | 1 | Address request strobe |
| req_kind | input | 3 | Access kind (0 fetch, 1 data, 2 extra, 3 push, 4 pop, 5 stack read) |
| req_ea | input | 16 | Effective address for data and extra kinds |
| ins_len | input | 4 | Instruction-pointer advance applied by a fetch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register chosen for writing |
| wr_data | input | 16 | Value to write |
| addr_out | output | 20 | Physical address |
| addr_vld | output | 1 | Address valid, one cycle after a request |

## Verification
The hardest case to reach from the ports is a write that lands in the same cycle as a request stepping the same pointer. A stack-pointer write is issued together with a push, and an instruction-pointer write together with a fetch. The bench then issues a stack read and a fetch to see which value survived. Stack-pointer and instruction-pointer wrap past zero and FFFFh are reached by loading the pointers next to those limits first. Address wrap past bit 19 is reached by sweeping segments up to FFFFh with large offsets.

// File: rtl/seg_addr_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes: request kinds and register selects are 3-bit codes.
package seg_addr_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_DATA  = 3'd1,
        K_EXTRA = 3'd2,
        K_PUSH  = 3'd3,
        K_POP   = 3'd4,
        K_STACK = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } acc_kind_e;

    typedef enum logic [2:0] {
        SEL_CS  = 3'd0,
        SEL_DS  = 3'd1,
        SEL_SS  = 3'd2,
        SEL_ES  = 3'd3,
        SEL_IP  = 3'd4,
        SEL_SP  = 3'd5,
        SEL_NO6 = 3'd6,
        SEL_NO7 = 3'd7
    } reg_sel_e;

    // True for kinds that produce an address.
    function automatic logic kind_active(input logic [2:0] k);
        return k < 3'd6;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
// Module: seg_regfile
// Holds the four segments, the instruction pointer and the stack pointer.
// Applies pointer steps for fetch/push/pop requests, then the write port,
// so a write to a register wins over a step of that register.
// Assumes: synchronous active-low reset; STEP fits in OFF_W bits.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int LEN_W  = 4,
    parameter int STEP   = 2,
    parameter logic [SEG_W-1:0] CS_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_go,
    input  logic [2:0]       req_kind,
    input  logic [LEN_W-1:0] ins_len,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [OFF_W-1:0] wr_data,
    output logic [SEG_W-1:0] cs_q,
    output logic [SEG_W-1:0] ds_q,
    output logic [SEG_W-1:0] ss_q,
    output logic [SEG_W-1:0] es_q,
    output logic [OFF_W-1:0] ip_q,
    output logic [OFF_W-1:0] sp_q
);

    localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

    logic [SEG_W-1:0] cs_n, ds_n, ss_n, es_n;
    logic [OFF_W-1:0] ip_n, sp_n;

    // Next-state: pointer steps first, register writes override.
    always_comb begin
        cs_n = cs_q;
        ds_n = ds_q;
        ss_n = ss_q;
        es_n = es_q;
        ip_n = ip_q;
        sp_n = sp_q;
        if (req_go) begin
            case (acc_kind_e'(req_kind))
                K_FETCH: ip_n = ip_q + OFF_W'(ins_len);
                K_PUSH:  sp_n = sp_q - STEP_V;
                K_POP:   sp_n = sp_q + STEP_V;
                default: ;
            endcase
        end
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CS:  cs_n = SEG_W'(wr_data);
                SEL_DS:  ds_n = SEG_W'(wr_data);
                SEL_SS:  ss_n = SEG_W'(wr_data);
                SEL_ES:  es_n = SEG_W'(wr_data);
                SEL_IP:  ip_n = wr_data;
                SEL_SP:  sp_n = wr_data;
                default: ;
            endcase
        end
    end

    // Register update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= CS_RST;
            ds_q <= '0;
            ss_q <= '0;
            es_q <= '0;
            ip_q <= '0;
            sp_q <= '0;
        end else begin
            cs_q <= cs_n;
            ds_q <= ds_n;
            ss_q <= ss_n;
            es_q <= es_n;
            ip_q <= ip_n;
            sp_q <= sp_n;
        end
    end

    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_PUSH && !(wr_en && wr_sel == SEL_SP))
        |=> sp_q == $past(sp_q) - STEP_V);

    a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_POP && !(wr_en && wr_sel == SEL_SP))
        |=> sp_q == $past(sp_q) + STEP_V);

    a_r3_ip_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_FETCH && !(wr_en && wr_sel == SEL_IP))
        |=> ip_q == $past(ip_q) + OFF_W'($past(ins_len)));

    a_r9_sp_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SP) |=> sp_q == $past(wr_data));

    a_r8_stack_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_STACK && !wr_en)
        |=> ($stable(sp_q) && $stable(ip_q) && $stable(ss_q)));

endmodule

// File: rtl/seg_offset_sel.sv
// Module: seg_offset_sel
// Picks the segment and offset pair for each access kind. A push offset
// is the already-lowered stack pointer.
// Assumes: purely combinational; inactive kinds give zeros.
module seg_offset_sel
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int STEP  = 2
) (
    input  logic [2:0]       req_kind,
    input  logic [OFF_W-1:0] req_ea,
    input  logic [SEG_W-1:0] cs_q,
    input  logic [SEG_W-1:0] ds_q,
    input  logic [SEG_W-1:0] ss_q,
    input  logic [SEG_W-1:0] es_q,
    input  logic [OFF_W-1:0] ip_q,
    input  logic [OFF_W-1:0] sp_q,
    output logic [SEG_W-1:0] seg_sel,
    output logic [OFF_W-1:0] off_sel
);

    localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

    // Segment/offset choice per kind.
    always_comb begin
        seg_sel = '0;
        off_sel = '0;
        case (acc_kind_e'(req_kind))
            K_FETCH: begin seg_sel = cs_q; off_sel = ip_q;          end
            K_DATA:  begin seg_sel = ds_q; off_sel = req_ea;        end
            K_EXTRA: begin seg_sel = es_q; off_sel = req_ea;        end
            K_PUSH:  begin seg_sel = ss_q; off_sel = sp_q - STEP_V; end
            K_POP:   begin seg_sel = ss_q; off_sel = sp_q;          end
            K_STACK: begin seg_sel = ss_q; off_sel = sp_q;          end
            default: ;
        endcase
    end

endmodule

// File: rtl/seg_phys_adder.sv
// Module: seg_phys_adder
// Shifts the segment left by SHIFT and adds the zero-extended offset.
// The result is truncated to ADDR_W bits, so the top carry is dropped.
// Assumes: OFF_W <= SEG_W + SHIFT.
module seg_phys_adder #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);

    logic [ADDR_W-1:0] base;

    // Shift-and-add with wrap at ADDR_W bits.
    always_comb begin
        base = {seg, {SHIFT{1'b0}}};
        phys = base + ADDR_W'(off);
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Registers one physical address per active request, one cycle later.
// Assumes: synchronous active-low reset; one request per cycle at most.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int LEN_W = 4,
    parameter int STEP  = 2,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_go,
    input  logic [2:0]        req_kind,
    input  logic [OFF_W-1:0]  req_ea,
    input  logic [LEN_W-1:0]  ins_len,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [OFF_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_vld
);

    logic [SEG_W-1:0]  cs_q, ds_q, ss_q, es_q;
    logic [OFF_W-1:0]  ip_q, sp_q;
    logic [SEG_W-1:0]  seg_sel;
    logic [OFF_W-1:0]  off_sel;
    logic [ADDR_W-1:0] phys;
    logic              take;

    seg_regfile #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .STEP(STEP), .CS_RST('1)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_kind(req_kind),
        .ins_len(ins_len), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cs_q(cs_q), .ds_q(ds_q), .ss_q(ss_q), .es_q(es_q),
        .ip_q(ip_q), .sp_q(sp_q)
    );

    seg_offset_sel #(.SEG_W(SEG_W), .OFF_W(OFF_W), .STEP(STEP)) i_sel (
        .req_kind(req_kind), .req_ea(req_ea),
        .cs_q(cs_q), .ds_q(ds_q), .ss_q(ss_q), .es_q(es_q),
        .ip_q(ip_q), .sp_q(sp_q),
        .seg_sel(seg_sel), .off_sel(off_sel)
    );

    seg_phys_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) i_add (
        .seg(seg_sel), .off(off_sel), .phys(phys)
    );

    // Request acceptance for address-producing kinds.
    always_comb take = req_go && kind_active(req_kind);

    // Output register: address and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
        end else begin
            addr_vld <= take;
            if (take) addr_out <= phys;
        end
    end

    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind < 3'd6) |=> addr_vld);

    a_r2_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_go && req_kind < 3'd6) |=> !addr_vld);

    a_r4_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_DATA)
        |=> addr_out == ADDR_W'({$past(ds_q), {SHIFT{1'b0}}} + ADDR_W'($past(req_ea))));

    a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_go && req_kind == K_FETCH)
        |=> addr_out == ADDR_W'({$past(cs_q), {SHIFT{1'b0}}} + ADDR_W'($past(ip_q))));

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_go = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_ea = '0;
    logic [3:0]  ins_len = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [19:0] addr_out;
    logic        addr_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model: 0 CS, 1 DS, 2 SS, 3 ES, 4 IP, 5 SP
    logic [15:0] m [0:5];

    always #10 clk = ~clk;

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_kind(req_kind),
        .req_ea(req_ea), .ins_len(ins_len), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .addr_out(addr_out), .addr_vld(addr_vld)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [19:0] p;
        p = {s, 4'h0} + {4'h0, o};
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, then check the registered output.
    task automatic op(input logic go, input logic [2:0] k, input logic [15:0] ea,
                      input logic [3:0] len, input logic we, input logic [2:0] ws,
                      input logic [15:0] wd, input string tag);
        logic        ev;
        logic [19:0] ea_exp;
        ev = go && (k < 3'd6);
        ea_exp = '0;
        @(negedge clk);
        req_go = go; req_kind = k; req_ea = ea; ins_len = len;
        wr_en = we; wr_sel = ws; wr_data = wd;
        if (go) begin
            case (k)
                3'd0: begin ea_exp = phys(m[0], m[4]); m[4] = m[4] + {12'h0, len}; end
                3'd1: ea_exp = phys(m[1], ea);
                3'd2: ea_exp = phys(m[3], ea);
                3'd3: begin m[5] = m[5] - 16'd2; ea_exp = phys(m[2], m[5]); end
                3'd4: begin ea_exp = phys(m[2], m[5]); m[5] = m[5] + 16'd2; end
                3'd5: ea_exp = phys(m[2], m[5]);
                default: ;
            endcase
        end
        if (we && ws < 3'd6) m[ws] = wd;
        @(negedge clk);
        req_go = 1'b0; wr_en = 1'b0;
        check(addr_vld == ev, {tag, " vld"}, {19'h0, addr_vld}, {19'h0, ev});
        if (ev) check(addr_out == ea_exp, {tag, " addr"}, addr_out, ea_exp);
    endtask

    task automatic wr(input logic [2:0] ws, input logic [15:0] wd);
        op(1'b0, 3'd0, 16'h0, 4'h0, 1'b1, ws, wd, "R9 write");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%05h expected=%05h", 20'h0, 20'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m[0] = 16'hFFFF;
        for (int i = 1; i < 6; i++) m[i] = 16'h0;
        repeat (3) @(negedge clk);
        check(addr_vld == 1'b0, "R1 reset vld", {19'h0, addr_vld}, 20'h0);
        rst_n = 1'b1;
        // R1: reset values seen through fetch and stack kinds
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R1 R3 fetch after reset");
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R1 R8 stack after reset");
        op(1'b0, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R2 idle");
        // R6/R7: stack pointer wrap below zero
        op(1'b1, 3'd3, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R6 push wrap");
        op(1'b1, 3'd4, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R7 pop wrap");
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R7 R8 sp back");
        // R4/R10: data segment sweep including top segments
        for (int i = 0; i < 300; i++) begin
            logic [15:0] s;
            s = (i < 256) ? 16'(i * 257) ^ 16'h00F0 : 16'hFFFF - 16'(i - 256);
            wr(3'd1, s);
            op(1'b1, 3'd1, 16'(i * 16'h2F1) ^ 16'hF00F, 4'h0, 1'b0, 3'd0, 16'h0, "R4 R10 data");
        end
        wr(3'd1, 16'hFFFF);
        op(1'b1, 3'd1, 16'h0010, 4'h0, 1'b0, 3'd0, 16'h0, "R10 wrap to zero");
        op(1'b1, 3'd1, 16'hFFFF, 4'h0, 1'b0, 3'd0, 16'h0, "R10 wrap high");
        wr(3'd1, 16'h05C0);
        op(1'b1, 3'd1, 16'h0050, 4'h0, 1'b0, 3'd0, 16'h0, "R4 example");
        // R5: extra segment sweep
        for (int i = 0; i < 64; i++) begin
            wr(3'd3, 16'(i * 16'h0403));
            op(1'b1, 3'd2, 16'(i * 16'h1111), 4'h0, 1'b0, 3'd0, 16'h0, "R5 extra");
        end
        // R3: fetch with every length, pointer wrap
        wr(3'd0, 16'h0400);
        wr(3'd4, 16'h0056);
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R3 example");
        wr(3'd4, 16'hFFF0);
        for (int l = 0; l < 16; l++)
            op(1'b1, 3'd0, 16'h0, 4'(l), 1'b0, 3'd0, 16'h0, "R3 fetch step");
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R3 ip after wrap");
        // R6/R7/R8: push/pop sequences
        wr(3'd2, 16'h0A00);
        wr(3'd5, 16'h0100);
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R8 example");
        for (int i = 0; i < 8; i++)
            op(1'b1, 3'd3, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R6 push seq");
        for (int i = 0; i < 8; i++)
            op(1'b1, 3'd4, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R7 pop seq");
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R8 restored");
        // R9: write collides with step of the same register
        op(1'b1, 3'd3, 16'h0, 4'h0, 1'b1, 3'd5, 16'h1234, "R9 push+write sp");
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R9 sp write wins");
        op(1'b1, 3'd0, 16'h0, 4'h3, 1'b1, 3'd4, 16'h2000, "R9 fetch+write ip");
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R9 ip write wins");
        op(1'b1, 3'd1, 16'h0004, 4'h0, 1'b1, 3'd1, 16'h7777, "R9 old ds used");
        op(1'b1, 3'd1, 16'h0004, 4'h0, 1'b0, 3'd0, 16'h0, "R9 new ds");
        // R9: codes 6 and 7 write nothing
        wr(3'd6, 16'hBEEF);
        wr(3'd7, 16'hBEEF);
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R9 sel6/7 ignored sp");
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R9 sel6/7 ignored ip");
        // R2: kinds 6 and 7 give no address and change nothing
        op(1'b1, 3'd6, 16'h0, 4'hF, 1'b0, 3'd0, 16'h0, "R2 kind6");
        op(1'b1, 3'd7, 16'h0, 4'hF, 1'b0, 3'd0, 16'h0, "R2 kind7");
        op(1'b1, 3'd5, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R2 sp after kind6/7");
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R2 ip after kind6/7");
        op(1'b0, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R2 vld drops");
        // R1: reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(addr_vld == 1'b0, "R1 vld after reset", {19'h0, addr_vld}, 20'h0);
        m[0] = 16'hFFFF;
        for (int i = 1; i < 6; i++) m[i] = 16'h0;
        op(1'b1, 3'd0, 16'h0, 4'h0, 1'b0, 3'd0, 16'h0, "R1 cs reset");
        op(1'b1, 3'd1, 16'h0ABC, 4'h0, 1'b0, 3'd0, 16'h0, "R1 ds reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule